// File: doc/BRIEF.md
# Multi-Block DMA Channel Sequencer

This block runs one DMA channel that moves data as a chain of blocks. Software programs the source address, the destination address, a control word and a link pointer, then sets the enable bit. The channel copies one block of words from the source to the destination. Each word takes one read and then one write on a word-wide memory master port.

At the end of each block the sequencer decides what happens next. It may finish the transfer, stop until software acknowledges the block, or go straight on. When a nonzero link pointer is present, it fetches a four-word list item from memory. The destination, link and control registers are taken from that item. The source address is never taken from the item: every block after the first restarts from the source address software first wrote.

The memory master port uses valid/ready. A request (address, write flag, write data) is held unchanged while `mem_req_valid` is high and `mem_req_ready` is low, and it is taken on the first edge where both are high. For every accepted read, memory returns exactly one `mem_rsp_valid` pulse with the data, in a later cycle. The sequencer waits for that pulse, so responses cannot be back-pressured. The register port is a plain one-cycle write strobe plus a combinational read mux.

Top module: `mdma_seq`

## Requirements
- R1: Every block after the first starts reading at the source value software last wrote to register 0, whatever the source address reached in the previous block.
- R2: Between blocks with a nonzero link register (index 2), the sequencer reads four words at link, link+4, link+8 and link+12, in the order source, destination, link, control. It then replaces the destination (index 1), link and control (index 3) registers with the last three of those words.
- R3: The source word of a list item is discarded. The current source register is never changed during a list fetch.
- R4: When control bit 12 (interrupt enable) and mask register bit 0 (index 6) are both 1, the end of each block sets block status (index 9, bit 0) and `irq_block`. If more blocks follow, the channel stalls until a 1 is written to bit 0 of index 7.
- R5: While stalled, the channel issues no memory request.
- R6: When interrupt enable or the mask bit is 0, the next block starts with no stall and block status stays 0.
- R7: A block that ends with config bit 0 (index 4, source reload) at 0 and a zero link register ends the transfer. This sets done status (index 9, bit 1) and `irq_done`, and clears enable (index 5, bit 0). A nonzero link register always continues the chain.
- R8: Control bits 11:0 give the block size in words. Each word is one read of the source and then one write of that data to the destination, and both addresses step by 4. A pending request stays stable until it is accepted.
- R9: Status bits are sticky. Writing 1 to bit 0 of index 7 clears block status, and writing 1 to bit 0 of index 8 clears done status.
- R10: While the channel is busy, writes to enable, source, destination, link and control have no effect.
- R11: After reset, all registers read 0, both interrupts are low and no memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid, one pulse per accepted read |
| mem_rsp_rdata | input | 32 | Read data |
| irq_block | output | 1 | Block-complete interrupt (sticky) |
| irq_done | output | 1 | Transfer-complete interrupt (sticky) |

## Verification
The copy path is tried in four settings:
- a single block;
- a three-block chain driven only by list items;
- a reloading block that stalls under an unmasked interrupt;
- a masked two-block chain.

The chain case separates a source that is reloaded from one that keeps counting, and from one taken from the list item, because the item's source word points at different data. The stall case separates stalling from running on by watching memory traffic while the status bit is set. It also checks that an enable write made during the stall leaves the channel running. The masked case shows that an enabled interrupt alone neither stalls the channel nor sets status. Memory ready is withheld in a repeating pattern so that held requests are exercised.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
  localparam int RIDX_W = 4;
  localparam int NREG   = 1 << RIDX_W;

  localparam logic [RIDX_W-1:0] RA_SRC  = 4'd0;
  localparam logic [RIDX_W-1:0] RA_DST  = 4'd1;
  localparam logic [RIDX_W-1:0] RA_LNK  = 4'd2;
  localparam logic [RIDX_W-1:0] RA_CTL  = 4'd3;
  localparam logic [RIDX_W-1:0] RA_CFG  = 4'd4;
  localparam logic [RIDX_W-1:0] RA_ENA  = 4'd5;
  localparam logic [RIDX_W-1:0] RA_MASK = 4'd6;
  localparam logic [RIDX_W-1:0] RA_BCLR = 4'd7;
  localparam logic [RIDX_W-1:0] RA_DCLR = 4'd8;
  localparam logic [RIDX_W-1:0] RA_STAT = 4'd9;

  localparam int LLI_WORDS = 4;
  localparam int LLI_DST   = 1;
  localparam int LLI_LNK   = 2;
  localparam int LLI_CTL   = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_RD_REQ, S_RD_WAIT, S_WR_REQ,
    S_BLK_END, S_STALL, S_NEXT, S_L_REQ, S_L_WAIT
  } seq_state_t;
endpackage

// File: rtl/mdma_regif.sv
module mdma_regif
  import mdma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              reg_wr,
  input  logic [RIDX_W-1:0] reg_addr,
  output logic [NREG-1:0]   wr_sel,
  input  logic [DW-1:0]     v_src,
  input  logic [DW-1:0]     v_dst,
  input  logic [DW-1:0]     v_lnk,
  input  logic [DW-1:0]     v_ctl,
  input  logic              v_reload,
  input  logic              v_enable,
  input  logic              v_mask,
  input  logic              v_st_blk,
  input  logic              v_st_done,
  output logic [DW-1:0]     reg_rdata
);
  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign wr_sel[g] = reg_wr && (reg_addr == RIDX_W'(g));
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_SRC:  reg_rdata = v_src;
      RA_DST:  reg_rdata = v_dst;
      RA_LNK:  reg_rdata = v_lnk;
      RA_CTL:  reg_rdata = v_ctl;
      RA_CFG:  reg_rdata[0] = v_reload;
      RA_ENA:  reg_rdata[0] = v_enable;
      RA_MASK: reg_rdata[0] = v_mask;
      RA_STAT: reg_rdata[1:0] = {v_st_done, v_st_blk};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdma_engine.sv
module mdma_engine
  import mdma_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] wr_sel,
  input  logic [DW-1:0]   wdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [DW-1:0]   mem_req_addr,
  output logic [DW-1:0]   mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_rdata,
  output logic [DW-1:0]   cur_src,
  output logic [DW-1:0]   cur_dst,
  output logic [DW-1:0]   lnk,
  output logic [DW-1:0]   ctl,
  output logic            reload,
  output logic            enable,
  output logic            mask,
  output logic            st_blk,
  output logic            st_done,
  output logic            busy,
  output logic            stalled,
  output logic            fetching
);
  localparam int FI_W    = $clog2(LLI_WORDS);
  localparam int IEN_BIT = CNT_W;

  seq_state_t        state;
  logic [DW-1:0]     src_init, fbase, dbuf;
  logic [CNT_W-1:0]  cnt;
  logic [FI_W-1:0]   fidx;
  logic              irq_arm, last_blk, bclr;

  assign irq_arm  = ctl[IEN_BIT] && mask;
  assign last_blk = !reload && (lnk == '0);
  assign bclr     = wr_sel[RA_BCLR] && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; src_init <= '0; cur_src <= '0; cur_dst <= '0;
      lnk <= '0; ctl <= '0; reload <= 1'b0; enable <= 1'b0; mask <= 1'b0;
      st_blk <= 1'b0; st_done <= 1'b0; fbase <= '0; dbuf <= '0;
      cnt <= '0; fidx <= '0;
    end else begin
      if (wr_sel[RA_CFG])  reload <= wdata[0];
      if (wr_sel[RA_MASK]) mask   <= wdata[0];
      if (bclr) st_blk <= 1'b0;
      if (wr_sel[RA_DCLR] && wdata[0]) st_done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (wr_sel[RA_SRC]) begin src_init <= wdata; cur_src <= wdata; end
          if (wr_sel[RA_DST]) cur_dst <= wdata;
          if (wr_sel[RA_LNK]) lnk <= wdata;
          if (wr_sel[RA_CTL]) ctl <= wdata;
          if (wr_sel[RA_ENA] && wdata[0]) begin
            enable <= 1'b1;
            state  <= S_START;
          end
        end
        S_START: begin
          cnt     <= ctl[CNT_W-1:0];
          cur_src <= src_init;
          state   <= (ctl[CNT_W-1:0] == '0) ? S_BLK_END : S_RD_REQ;
        end
        S_RD_REQ: if (mem_req_ready) state <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rsp_valid) begin
          dbuf  <= mem_rsp_rdata;
          state <= S_WR_REQ;
        end
        S_WR_REQ: if (mem_req_ready) begin
          cur_src <= cur_src + DW'(4);
          cur_dst <= cur_dst + DW'(4);
          cnt     <= cnt - CNT_W'(1);
          state   <= (cnt == CNT_W'(1)) ? S_BLK_END : S_RD_REQ;
        end
        S_BLK_END: begin
          if (irq_arm) st_blk <= 1'b1;
          if (last_blk) begin
            st_done <= 1'b1;
            enable  <= 1'b0;
            state   <= S_IDLE;
          end else begin
            state <= irq_arm ? S_STALL : S_NEXT;
          end
        end
        S_STALL: if (bclr) state <= S_NEXT;
        S_NEXT: begin
          if (lnk != '0) begin
            fbase <= lnk;
            fidx  <= '0;
            state <= S_L_REQ;
          end else begin
            state <= S_START;
          end
        end
        S_L_REQ: if (mem_req_ready) state <= S_L_WAIT;
        S_L_WAIT: if (mem_rsp_valid) begin
          if (fidx == FI_W'(LLI_DST)) cur_dst <= mem_rsp_rdata;
          if (fidx == FI_W'(LLI_LNK)) lnk     <= mem_rsp_rdata;
          if (fidx == FI_W'(LLI_CTL)) ctl     <= mem_rsp_rdata;
          if (fidx == FI_W'(LLI_WORDS - 1)) begin
            state <= S_START;
          end else begin
            fidx  <= fidx + FI_W'(1);
            state <= S_L_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign stalled  = (state == S_STALL);
  assign fetching = (state == S_L_REQ) || (state == S_L_WAIT);

  assign mem_req_valid = (state == S_RD_REQ) || (state == S_WR_REQ) || (state == S_L_REQ);
  assign mem_req_we    = (state == S_WR_REQ);
  assign mem_req_wdata = dbuf;
  always_comb begin
    if (state == S_RD_REQ)      mem_req_addr = cur_src;
    else if (state == S_WR_REQ) mem_req_addr = cur_dst;
    else                        mem_req_addr = fbase + (DW'(fidx) << 2);
  end
endmodule

// File: rtl/mdma_seq.sv
module mdma_seq
  import mdma_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RIDX_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [DW-1:0]     mem_req_addr,
  output logic [DW-1:0]     mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_rdata,
  output logic              irq_block,
  output logic              irq_done
);
  logic [NREG-1:0] wr_sel;
  logic [DW-1:0]   cur_src, cur_dst, lnk, ctl;
  logic            reload, enable, mask, st_blk, st_done;
  logic            busy, stalled, fetching;

  mdma_regif #(.DW(DW)) regif_i (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .wr_sel(wr_sel),
    .v_src(cur_src), .v_dst(cur_dst), .v_lnk(lnk), .v_ctl(ctl),
    .v_reload(reload), .v_enable(enable), .v_mask(mask),
    .v_st_blk(st_blk), .v_st_done(st_done), .reg_rdata(reg_rdata)
  );

  mdma_engine #(.DW(DW), .CNT_W(CNT_W)) engine_i (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(reg_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata),
    .cur_src(cur_src), .cur_dst(cur_dst), .lnk(lnk), .ctl(ctl),
    .reload(reload), .enable(enable), .mask(mask),
    .st_blk(st_blk), .st_done(st_done),
    .busy(busy), .stalled(stalled), .fetching(fetching)
  );

  assign irq_block = st_blk;
  assign irq_done  = st_done;
endmodule

// File: rtl/mdma_seq_chk.sv
module mdma_seq_chk
  import mdma_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [RIDX_W-1:0] reg_addr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [DW-1:0]     mem_req_addr,
  input logic [DW-1:0]     cur_src,
  input logic              busy,
  input logic              stalled,
  input logic              fetching,
  input logic              irq_block,
  input logic              irq_done
);
  p_src_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetching && $past(fetching)) |-> $stable(cur_src));

  p_stall_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> irq_block);

  p_stall_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !mem_req_valid);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> !busy);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

  p_enable_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && reg_wr && reg_addr == RA_ENA) |=> busy);
endmodule

bind mdma_seq mdma_seq_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .cur_src(cur_src), .busy(busy), .stalled(stalled), .fetching(fetching),
  .irq_block(irq_block), .irq_done(irq_done)
);

// File: tb/mdma_seq_tb.sv
module mdma_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        irq_block, irq_done;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] exp_a[$], exp_d[$];
  bit          rsp_pend = 0;
  logic [31:0] rsp_data = '0;
  int          rdy_cnt = 0;
  int          wr_seen = 0;

  always #4 clk = ~clk;

  mdma_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .irq_block(irq_block), .irq_done(irq_done)
  );

  function automatic logic [31:0] init_val(int i);
    return 32'h3C00_0000 + (i << 12) + i * 5;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rsp_pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_rdata = rsp_data;
      rsp_pend = 0;
    end
    rdy_cnt++;
    mem_req_ready = (rdy_cnt % 3) != 0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr[11:2]] = mem_req_wdata;
        wr_seen++;
        if (exp_a.size() == 0) begin
          chk(0, "R8 unexpected write", mem_req_addr, 32'h0);
        end else begin
          logic [31:0] ea, ed;
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          chk(mem_req_addr == ea, "R8/R1/R2 write address", mem_req_addr, ea);
          chk(mem_req_wdata == ed, "R8/R1/R3 write data", mem_req_wdata, ed);
        end
      end else begin
        rsp_pend = 1;
        rsp_data = mem[mem_req_addr[11:2]];
      end
    end
  end

  task automatic push_block(logic [31:0] src, logic [31:0] dst, int n);
    for (int k = 0; k < n; k++) begin
      exp_a.push_back(dst + 4 * k);
      exp_d.push_back(init_val(int'(src >> 2) + k));
    end
  endtask

  task automatic put_lli(logic [31:0] at, logic [31:0] s, logic [31:0] d,
                         logic [31:0] l, logic [31:0] c);
    mem[at >> 2] = s; mem[(at >> 2) + 1] = d;
    mem[(at >> 2) + 2] = l; mem[(at >> 2) + 3] = c;
  endtask

  task automatic wreg(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(string req);
    logic [31:0] v;
    int guard = 0;
    v = 1;
    while (v[0] && guard < 5000) begin
      rreg(4'd5, v);
      guard++;
    end
    chk(v[0] == 1'b0, req, v, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w0;
    for (int i = 0; i < 1024; i++) mem[i] = init_val(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(mem_req_valid == 1'b0, "R11 no request", {31'b0, mem_req_valid}, 0);
    chk({irq_block, irq_done} == 2'b00, "R11 irqs low", {30'b0, irq_block, irq_done}, 0);
    rreg(4'd5, v); chk(v == 0, "R11 enable reset", v, 0);
    rreg(4'd9, v); chk(v == 0, "R11 status reset", v, 0);
    rreg(4'd3, v); chk(v == 0, "R11 control reset", v, 0);

    // single block, transfer ends at once (R8, R7)
    push_block(32'h100, 32'h400, 3);
    wreg(4'd0, 32'h100); wreg(4'd1, 32'h400); wreg(4'd3, 32'd3); wreg(4'd5, 1);
    wait_idle("R7 enable cleared after single block");
    rreg(4'd9, v); chk(v == 32'h2, "R7 done status, no block status", v, 32'h2);
    chk(irq_done == 1'b1, "R7 irq_done", {31'b0, irq_done}, 1);
    wreg(4'd8, 1);
    rreg(4'd9, v); chk(v == 0, "R9 done cleared", v, 0);

    // three-block chain driven by list items (R1, R2, R3)
    put_lli(32'h800, 32'h900, 32'h500, 32'h810, 32'd3);
    put_lli(32'h810, 32'h900, 32'h600, 32'h0, 32'd2);
    push_block(32'h100, 32'h400, 3);
    push_block(32'h100, 32'h500, 3);
    push_block(32'h100, 32'h600, 2);
    wreg(4'd0, 32'h100); wreg(4'd1, 32'h400); wreg(4'd2, 32'h800);
    wreg(4'd3, 32'd3); wreg(4'd4, 0); wreg(4'd5, 1);
    wait_idle("R7 chain completes");
    rreg(4'd1, v); chk(v == 32'h608, "R2 destination from list", v, 32'h608);
    rreg(4'd2, v); chk(v == 32'h0, "R2 link from list", v, 32'h0);
    rreg(4'd3, v); chk(v == 32'd2, "R2 control from list", v, 32'd2);
    rreg(4'd0, v); chk(v == 32'h108, "R3 source reloaded, not from list", v, 32'h108);
    wreg(4'd8, 1);

    // stall under unmasked interrupt with source reload (R4, R5, R10, R1)
    push_block(32'h200, 32'h440, 2);
    wreg(4'd0, 32'h200); wreg(4'd1, 32'h440); wreg(4'd2, 0);
    wreg(4'd3, (32'd1 << 12) | 32'd2); wreg(4'd4, 1); wreg(4'd6, 1); wreg(4'd5, 1);
    v = 0;
    for (int g = 0; g < 2000 && !v[0]; g++) rreg(4'd9, v);
    chk(v[0] == 1'b1, "R4 block status set", v, 32'h1);
    w0 = wr_seen;
    repeat (20) @(negedge clk);
    chk(wr_seen == w0, "R5 no traffic while stalled", wr_seen, w0);
    chk(mem_req_valid == 1'b0, "R5 request idle while stalled", {31'b0, mem_req_valid}, 0);
    wreg(4'd5, 0);
    rreg(4'd5, v); chk(v == 1, "R10 enable write ignored while busy", v, 1);
    wreg(4'd1, 32'h7F0);
    push_block(32'h200, 32'h448, 2);
    wreg(4'd4, 0);
    wreg(4'd7, 1);
    wait_idle("R7 stall case completes");
    rreg(4'd1, v); chk(v == 32'h450, "R10 destination write ignored while busy", v, 32'h450);
    rreg(4'd9, v); chk(v == 32'h3, "R4 final block sets both status bits", v, 32'h3);
    wreg(4'd7, 1);
    rreg(4'd9, v); chk(v == 32'h2, "R9 block clear leaves done", v, 32'h2);
    wreg(4'd8, 1);
    rreg(4'd9, v); chk(v == 0, "R9 both cleared", v, 0);

    // interrupt enabled but masked: no stall (R6)
    put_lli(32'h820, 32'h0, 32'h4C0, 32'h0, (32'd1 << 12) | 32'd2);
    push_block(32'h300, 32'h480, 1);
    push_block(32'h300, 32'h4C0, 2);
    wreg(4'd6, 0);
    wreg(4'd0, 32'h300); wreg(4'd1, 32'h480); wreg(4'd2, 32'h820);
    wreg(4'd3, (32'd1 << 12) | 32'd1); wreg(4'd5, 1);
    wait_idle("R6 masked chain runs to completion");
    rreg(4'd9, v); chk(v == 32'h2, "R6 no block status when masked", v, 32'h2);
    chk(irq_block == 1'b0, "R6 irq_block low", {31'b0, irq_block}, 0);

    chk(exp_a.size() == 0, "R8 all expected writes seen", exp_a.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule